// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This block sits next to a processor's bus and watches every bus cycle. Each of its two channels, A and B, holds a set of conditions. A channel matches a cycle only when all of them agree: the address space identifier (ASID), the break address under an address mask, the cycle kind (instruction fetch or data access), the direction, an optional operand size and, on channel B only, an optional data value under a data mask. When a channel matches, the block raises a one-cycle trap request that names the channel or channels that caused it. It also sets a sticky flag for each channel. The two channels work independently.

Settings are loaded through a simple register write port. The bus side is a monitor: it samples a cycle whenever `cyc_valid` is high and never stalls the bus, so there is no ready signal and no back-pressure. Instruction-fetch matches can be reported before the instruction runs (pre-execution). Otherwise they wait for the next `insn_retire` strobe.

Register map, indexed by `reg_addr`. All registers reset to zero.

| Index | Register | Meaning |
|---|---|---|
| 0 | CTRL | bit0 data-compare enable (channel B); bit1 pre-execution fetch break, channel A; bit2 pre-execution fetch break, channel B. Any write to CTRL clears both sticky flags. |
| 1 / 5 | ASID | 8-bit ASID for channel A / channel B |
| 2 / 6 | ADDR | break address for channel A / channel B |
| 3 / 7 | AMASK | 2-bit mask code for channel A / channel B |
| 4 / 8 | COND | cycle condition for channel A / channel B, laid out as shown below |
| 9 | BDATA | channel B data value, right-aligned |
| 10 | BDMASK | channel B data mask; a 1 bit means that bit is ignored |

COND layout:

| Bits | Field | Values |
|---|---|---|
| 6 | enable | 1 enables the channel |
| 5:4 | size | 0 any, 1 byte, 2 word, 3 longword |
| 3:2 | direction | 0 any, 1 read, 2 write, 3 never |
| 1:0 | kind | 0 any, 1 fetch, 2 data, 3 never |

Other indices are ignored.

Bus signals:
- `cyc_size` is 0 for a byte, 1 for a word and 2 for a longword. Code 3 is treated as a longword for address coverage and matches only a size condition of "any".
- Data lanes are little-endian. A byte uses bits 8k+7:8k, where k = address[1:0]. A word uses bits 15:0 when address[1] is 0 and bits 31:16 when it is 1.

Top module: `bus_break_unit`

## Requirements
- R1: A channel matches only when `cyc_asid` equals that channel's ASID register.
- R2: Mask code 0 compares all address bits. Codes 1, 2 and 3 ignore the low 10, 12 and 16 address bits respectively.
- R3: When the size field is 0 (any), the cycle matches if it covers the break address. A longword ignores address bits 1:0, a word ignores bit 0, and a byte must hit the exact address.
- R4: When the size field is nonzero, the bus size must equal it (byte=1, word=2, longword=3), and the address is compared exactly under the mask.
- R5: A condition with kind fetch (1) and direction write (2) never matches. A fetch condition whose break address is odd never matches.
- R6: When CTRL bit0 is 1, channel B also requires the selected data lane to equal BDATA on every bit where BDMASK is 0.
- R7: When CTRL bit0 is 0, channel B ignores the bus data entirely.
- R8: A fetch match on a channel whose pre-execution bit is 1 raises the trap on the next clock. With the bit 0, it raises the trap on the clock after the next `insn_retire` pulse.
- R9: The channels are independent. Each raises its own `trap_src` bit, and both may be set in the same cycle.
- R10: A valid matching data cycle gives `trap_req`=1 for exactly one clock, in the clock after the cycle. The channel's `match_flag` bit is set at the same time and stays set until CTRL is written.
- R11: A bus cycle presented in the same clock as a register write is judged against the settings in force before that write.
- R12: A channel with COND bit6 = 0, or whose kind or direction does not fit the cycle, never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 4 | register index |
| reg_wdata | input | 32 | register write data |
| cyc_valid | input | 1 | bus cycle present this clock |
| cyc_addr | input | 32 | bus cycle address |
| cyc_data | input | 32 | bus cycle data |
| cyc_asid | input | 8 | current address space identifier |
| cyc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_size | input | 2 | operand size code |
| insn_retire | input | 1 | an instruction finished executing |
| trap_req | output | 1 | one-clock break trap request |
| trap_src | output | 2 | channels causing the trap (bit0 A, bit1 B) |
| match_flag | output | 2 | sticky per-channel match flags |

## Verification
The bench builds the block with its default parameters: 32-bit address and data, 8-bit ASID, and ignore widths of 10, 12 and 16 for mask codes 1 to 3. A 32-bit data bus gives four byte lanes and two word lanes, so the lane selection for byte and word data compares can be reached. The 16-bit ignore width lets one test place a match and a miss on either side of a 64 KB boundary. Other sections of the bench cover:
- coverage by size for the exact-address and longword-aligned cases;
- the same-clock register write;
- deferred fetch traps released by `insn_retire`.

// File: rtl/brk_pkg.sv
package brk_pkg;

  localparam int NCH = 2;

  // bus operand size codes
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  // condition kind / direction codes
  localparam logic [1:0] K_ANY   = 2'd0;
  localparam logic [1:0] K_FETCH = 2'd1;
  localparam logic [1:0] K_DATA  = 2'd2;
  localparam logic [1:0] D_ANY   = 2'd0;
  localparam logic [1:0] D_READ  = 2'd1;
  localparam logic [1:0] D_WRITE = 2'd2;

  // register indices
  localparam int RI_CTRL   = 0;
  localparam int RI_CH0    = 1;   // channel n base = RI_CH0 + RI_STRIDE*n
  localparam int RI_STRIDE = 4;   // ASID, ADDR, AMASK, COND
  localparam int RI_BDATA  = 9;
  localparam int RI_BDMASK = 10;

  typedef struct packed {
    logic       en;
    logic [1:0] size;
    logic [1:0] dir;
    logic [1:0] kind;
  } cond_t;

endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int ASID_W  = 8,
  parameter int RADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [RADDR_W-1:0]            reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [NCH-1:0][ASID_W-1:0]    ch_asid,
  output logic [NCH-1:0][ADDR_W-1:0]    ch_addr,
  output logic [NCH-1:0][1:0]           ch_mcode,
  output cond_t [NCH-1:0]               ch_cond,
  output logic [DATA_W-1:0]             b_data,
  output logic [DATA_W-1:0]             b_dmask,
  output logic                          dbe,
  output logic [NCH-1:0]                pre_exec,
  output logic                          flag_clr
);

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata;

  function automatic logic hit_idx(input logic [RADDR_W-1:0] a, input int idx);
    return a == RADDR_W'(idx);
  endfunction

  assign flag_clr = reg_we && hit_idx(reg_addr, RI_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbe      <= 1'b0;
      pre_exec <= '0;
    end else if (flag_clr) begin
      dbe      <= reg_wdata[0];
      pre_exec <= reg_wdata[NCH:1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_data  <= '0;
      b_dmask <= '0;
    end else if (reg_we) begin
      if (hit_idx(reg_addr, RI_BDATA))  b_data  <= reg_wdata;
      if (hit_idx(reg_addr, RI_BDMASK)) b_dmask <= reg_wdata;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int BASE = RI_CH0 + RI_STRIDE * c;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ch_asid[c]  <= '0;
        ch_addr[c]  <= '0;
        ch_mcode[c] <= '0;
        ch_cond[c]  <= '0;
      end else if (reg_we) begin
        if (hit_idx(reg_addr, BASE))     ch_asid[c]  <= reg_wdata[ASID_W-1:0];
        if (hit_idx(reg_addr, BASE + 1)) ch_addr[c]  <= reg_wdata[ADDR_W-1:0];
        if (hit_idx(reg_addr, BASE + 2)) ch_mcode[c] <= reg_wdata[1:0];
        if (hit_idx(reg_addr, BASE + 3)) ch_cond[c]  <= cond_t'(reg_wdata[6:0]);
      end
    end
  end

endmodule

// File: rtl/brk_chan.sv
module brk_chan
  import brk_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int ASID_W   = 8,
  parameter int IGN1     = 10,
  parameter int IGN2     = 12,
  parameter int IGN3     = 16,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic              cyc_valid,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [DATA_W-1:0] cyc_data,
  input  logic [ASID_W-1:0] cyc_asid,
  input  logic              cyc_fetch,
  input  logic              cyc_write,
  input  logic [1:0]        cyc_size,
  input  logic [ASID_W-1:0] cfg_asid,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_mcode,
  input  cond_t             cfg_cond,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [DATA_W-1:0] cfg_dmask,
  input  logic              dbe,
  output logic              hit
);

  localparam logic [ADDR_W-1:0] LOW1 = {{(ADDR_W-IGN1){1'b0}}, {IGN1{1'b1}}};
  localparam logic [ADDR_W-1:0] LOW2 = {{(ADDR_W-IGN2){1'b0}}, {IGN2{1'b1}}};
  localparam logic [ADDR_W-1:0] LOW3 = {{(ADDR_W-IGN3){1'b0}}, {IGN3{1'b1}}};

  logic [ADDR_W-1:0] ign_mask;
  logic [ADDR_W-1:0] size_ign;
  logic asid_ok, addr_ok, size_ok, kind_ok, dir_ok, never, data_ok;

  assign asid_ok = (cyc_asid == cfg_asid);

  always_comb begin
    unique case (cfg_mcode)
      2'd0:    ign_mask = '0;
      2'd1:    ign_mask = LOW1;
      2'd2:    ign_mask = LOW2;
      default: ign_mask = LOW3;
    endcase
  end

  // size-free conditions match any access that covers the break byte
  always_comb begin
    size_ign = '0;
    if (cfg_cond.size == 2'd0) begin
      unique case (cyc_size)
        SZ_BYTE: size_ign = '0;
        SZ_WORD: size_ign = ADDR_W'(1);
        default: size_ign = ADDR_W'(3);
      endcase
    end
  end

  assign addr_ok = (((cyc_addr ^ cfg_addr) & ~(ign_mask | size_ign)) == '0);
  assign size_ok = (cfg_cond.size == 2'd0) || (cfg_cond.size == cyc_size + 2'd1);

  always_comb begin
    unique case (cfg_cond.kind)
      K_ANY:   kind_ok = 1'b1;
      K_FETCH: kind_ok = cyc_fetch;
      K_DATA:  kind_ok = !cyc_fetch;
      default: kind_ok = 1'b0;
    endcase
    unique case (cfg_cond.dir)
      D_ANY:   dir_ok = 1'b1;
      D_READ:  dir_ok = !cyc_write;
      D_WRITE: dir_ok = cyc_write;
      default: dir_ok = 1'b0;
    endcase
  end

  // fetches are reads at even addresses
  assign never = (cfg_cond.kind == K_FETCH) &&
                 ((cfg_cond.dir == D_WRITE) || cfg_addr[0]);

  if (HAS_DATA) begin : g_data
    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int SH_W  = OFF_W + 3;
    logic [SH_W-1:0]   shamt;
    logic [DATA_W-1:0] lane, lane_mask;

    always_comb begin
      unique case (cyc_size)
        SZ_BYTE: begin
          shamt     = {cyc_addr[OFF_W-1:0], 3'b000};
          lane_mask = DATA_W'(8'hFF);
        end
        SZ_WORD: begin
          shamt     = {cyc_addr[OFF_W-1:1], 4'b0000};
          lane_mask = DATA_W'(16'hFFFF);
        end
        default: begin
          shamt     = '0;
          lane_mask = '1;
        end
      endcase
    end

    assign lane    = cyc_data >> shamt;
    assign data_ok = !dbe || (((lane ^ cfg_data) & ~cfg_dmask & lane_mask) == '0);
  end else begin : g_nodata
    logic unused_data;
    assign unused_data = ^{cyc_data, cfg_data, cfg_dmask, dbe};
    assign data_ok     = 1'b1;
  end

  assign hit = cyc_valid && cfg_cond.en && asid_ok && addr_ok && size_ok &&
               kind_ok && dir_ok && !never && data_ok;

endmodule

// File: rtl/brk_trap.sv
module brk_trap
  import brk_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic           cyc_fetch,
  input  logic [NCH-1:0] pre_exec,
  input  logic           insn_retire,
  input  logic           flag_clr,
  output logic           trap_req,
  output logic [NCH-1:0] trap_src,
  output logic [NCH-1:0] match_flag
);

  logic [NCH-1:0] fire;
  logic [NCH-1:0] pend;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic deferred;
    assign deferred = hit[c] && cyc_fetch && !pre_exec[c];
    assign fire[c]  = (hit[c] && !deferred) || (pend[c] && insn_retire);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[c]       <= 1'b0;
        trap_src[c]   <= 1'b0;
        match_flag[c] <= 1'b0;
      end else begin
        if (deferred)         pend[c] <= 1'b1;
        else if (insn_retire) pend[c] <= 1'b0;
        trap_src[c]   <= fire[c];
        match_flag[c] <= fire[c] || (match_flag[c] && !flag_clr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trap_req <= 1'b0;
    else        trap_req <= |fire;
  end

endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import brk_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int ASID_W  = 8,
  parameter int RADDR_W = 4,
  parameter int IGN1    = 10,
  parameter int IGN2    = 12,
  parameter int IGN3    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              cyc_valid,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [DATA_W-1:0] cyc_data,
  input  logic [ASID_W-1:0] cyc_asid,
  input  logic              cyc_fetch,
  input  logic              cyc_write,
  input  logic [1:0]        cyc_size,
  input  logic              insn_retire,
  output logic              trap_req,
  output logic [1:0]        trap_src,
  output logic [1:0]        match_flag
);

  logic [NCH-1:0][ASID_W-1:0] ch_asid;
  logic [NCH-1:0][ADDR_W-1:0] ch_addr;
  logic [NCH-1:0][1:0]        ch_mcode;
  cond_t [NCH-1:0]            ch_cond;
  logic [DATA_W-1:0]          b_data, b_dmask;
  logic                       dbe, flag_clr;
  logic [NCH-1:0]             pre_exec, hit;

  brk_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ASID_W(ASID_W), .RADDR_W(RADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ch_asid(ch_asid), .ch_addr(ch_addr),
    .ch_mcode(ch_mcode), .ch_cond(ch_cond), .b_data(b_data),
    .b_dmask(b_dmask), .dbe(dbe), .pre_exec(pre_exec), .flag_clr(flag_clr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    brk_chan #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ASID_W(ASID_W),
      .IGN1(IGN1), .IGN2(IGN2), .IGN3(IGN3), .HAS_DATA(c == NCH - 1)
    ) u_chan (
      .cyc_valid(cyc_valid), .cyc_addr(cyc_addr), .cyc_data(cyc_data),
      .cyc_asid(cyc_asid), .cyc_fetch(cyc_fetch), .cyc_write(cyc_write),
      .cyc_size(cyc_size), .cfg_asid(ch_asid[c]), .cfg_addr(ch_addr[c]),
      .cfg_mcode(ch_mcode[c]), .cfg_cond(ch_cond[c]), .cfg_data(b_data),
      .cfg_dmask(b_dmask), .dbe(dbe), .hit(hit[c])
    );
  end

  brk_trap u_trap (
    .clk(clk), .rst_n(rst_n), .hit(hit), .cyc_fetch(cyc_fetch),
    .pre_exec(pre_exec), .insn_retire(insn_retire), .flag_clr(flag_clr),
    .trap_req(trap_req), .trap_src(trap_src), .match_flag(match_flag)
  );

endmodule

// File: rtl/bus_break_chk.sv
module bus_break_chk
  import brk_pkg::*;
#(
  parameter int ASID_W  = 8,
  parameter int RADDR_W = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_we,
  input logic [RADDR_W-1:0]         reg_addr,
  input logic                       cyc_valid,
  input logic [ASID_W-1:0]          cyc_asid,
  input logic                       insn_retire,
  input logic                       trap_req,
  input logic [1:0]                 trap_src,
  input logic [1:0]                 match_flag,
  input logic [NCH-1:0][ASID_W-1:0] ch_asid,
  input cond_t [NCH-1:0]            ch_cond
);

  AST_TRAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !$past(insn_retire) |-> $past(cyc_valid)); // R10

  AST_ASID_A: assert property (@(posedge clk) disable iff (!rst_n)
    trap_src[0] && !$past(insn_retire) |-> $past(cyc_asid) == $past(ch_asid[0])); // R1

  AST_ASID_B: assert property (@(posedge clk) disable iff (!rst_n)
    trap_src[1] && !$past(insn_retire) |-> $past(cyc_asid) == $past(ch_asid[1])); // R1

  AST_FLAG_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_src & ~match_flag) == 2'b00); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == RADDR_W'(RI_CTRL)) |=> (match_flag & $past(match_flag)) == $past(match_flag)); // R10

  AST_FETCH_WRITE_A: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_retire && ch_cond[0].kind == K_FETCH && ch_cond[0].dir == D_WRITE |=> !trap_src[0]); // R5

endmodule

bind bus_break_unit bus_break_chk #(.ASID_W(ASID_W), .RADDR_W(RADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .cyc_valid(cyc_valid), .cyc_asid(cyc_asid), .insn_retire(insn_retire),
  .trap_req(trap_req), .trap_src(trap_src), .match_flag(match_flag),
  .ch_asid(ch_asid), .ch_cond(ch_cond)
);

// File: tb/bus_break_unit_tb.sv
module bus_break_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        cyc_valid = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic [31:0] cyc_data = '0;
  logic [7:0]  cyc_asid = '0;
  logic        cyc_fetch = 1'b0;
  logic        cyc_write = 1'b0;
  logic [1:0]  cyc_size = '0;
  logic        insn_retire = 1'b0;
  logic        trap_req;
  logic [1:0]  trap_src;
  logic [1:0]  match_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  bus_break_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
    .cyc_data(cyc_data), .cyc_asid(cyc_asid), .cyc_fetch(cyc_fetch),
    .cyc_write(cyc_write), .cyc_size(cyc_size), .insn_retire(insn_retire),
    .trap_req(trap_req), .trap_src(trap_src), .match_flag(match_flag)
  );

  typedef struct packed {
    logic        fetch;
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] data;
    logic [7:0]  asid;
    logic [1:0]  exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd2, 32'h00123454, 32'h0,        8'h80, 2'b01},
    '{1'b0, 1'b0, 2'd1, 32'h00123456, 32'h0,        8'h80, 2'b01},
    '{1'b0, 1'b0, 2'd0, 32'h00123456, 32'h0,        8'h80, 2'b01},
    '{1'b0, 1'b0, 2'd0, 32'h00123457, 32'h0,        8'h80, 2'b00},
    '{1'b0, 1'b0, 2'd1, 32'h00123454, 32'h0,        8'h80, 2'b00},
    '{1'b0, 1'b0, 2'd2, 32'h00123454, 32'h0,        8'h70, 2'b00},
    '{1'b0, 1'b1, 2'd1, 32'h00123456, 32'h0,        8'h80, 2'b00},
    '{1'b0, 1'b1, 2'd1, 32'h000AB000, 32'h0000A512, 8'h70, 2'b10},
    '{1'b0, 1'b1, 2'd1, 32'h000ABFFE, 32'hA5120000, 8'h70, 2'b10},
    '{1'b0, 1'b1, 2'd1, 32'h000AC000, 32'h0000A512, 8'h70, 2'b00},
    '{1'b0, 1'b1, 2'd1, 32'h000AB002, 32'h0000A512, 8'h70, 2'b00},
    '{1'b0, 1'b1, 2'd1, 32'h000AB004, 32'h0000A513, 8'h70, 2'b00},
    '{1'b0, 1'b1, 2'd0, 32'h000AB004, 32'h00000012, 8'h70, 2'b00},
    '{1'b1, 1'b0, 2'd1, 32'h00123456, 32'h0,        8'h80, 2'b00}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_cyc(input logic f, input logic w, input logic [1:0] s,
                         input logic [31:0] a, input logic [31:0] d, input logic [7:0] id);
    cyc_valid = 1'b1; cyc_fetch = f; cyc_write = w; cyc_size = s;
    cyc_addr = a; cyc_data = d; cyc_asid = id;
  endtask

  // one bus cycle; on return the registered result is visible
  task automatic bus(input logic f, input logic w, input logic [1:0] s,
                     input logic [31:0] a, input logic [31:0] d, input logic [7:0] id);
    @(negedge clk);
    set_cyc(f, w, s, a, d, id);
    @(negedge clk);
    cyc_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset trap_req", 32'(trap_req), 32'd0);
    check("R10 reset trap_src", 32'(trap_src), 32'd0);
    check("R10 reset match_flag", 32'(match_flag), 32'd0);

    // channel A: ASID 80, addr 00123456, mask 0, data read, any size
    reg_wr(4'd1, 32'h80);
    reg_wr(4'd2, 32'h00123456);
    reg_wr(4'd3, 32'd0);
    reg_wr(4'd4, 32'h46);
    // channel B: ASID 70, addr 000ABCDE, mask 2, data write word, data A512
    reg_wr(4'd5, 32'h70);
    reg_wr(4'd6, 32'h000ABCDE);
    reg_wr(4'd7, 32'd2);
    reg_wr(4'd8, 32'h6A);
    reg_wr(4'd9, 32'h0000A512);
    reg_wr(4'd10, 32'h0);
    reg_wr(4'd0, 32'h1);

    // table: R1 R2 R3 R4 R6 R12
    for (int i = 0; i < NV; i++) begin
      bus(VECS[i].fetch, VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].data, VECS[i].asid);
      check($sformatf("R1/R3/R4/R6/R12 vector %0d", i), 32'(trap_src), 32'(VECS[i].exp));
    end

    // R10: pulse length and sticky flags
    bus(1'b0, 1'b0, 2'd2, 32'h00123454, 32'h0, 8'h80);
    check("R10 trap pulse high", 32'(trap_req), 32'd1);
    @(negedge clk);
    check("R10 trap pulse one clock", 32'(trap_req), 32'd0);
    check("R10 flags sticky", 32'(match_flag), 32'd3);
    reg_wr(4'd0, 32'h1);
    check("R10 flags cleared by CTRL write", 32'(match_flag), 32'd0);

    // R6: masked data bit ignored
    reg_wr(4'd10, 32'h00000001);
    bus(1'b0, 1'b1, 2'd1, 32'h000AB004, 32'h0000A513, 8'h70);
    check("R6 data mask ignores bit0", 32'(trap_src), 32'd2);
    reg_wr(4'd10, 32'h0);

    // R7: data compare disabled
    reg_wr(4'd0, 32'h0);
    bus(1'b0, 1'b1, 2'd1, 32'h000AB010, 32'h00000000, 8'h70);
    check("R7 data ignored when disabled", 32'(trap_src), 32'd2);

    // R2: mask code 3 ignores low 16 bits
    reg_wr(4'd3, 32'd3);
    bus(1'b0, 1'b0, 2'd2, 32'h0012FFF0, 32'h0, 8'h80);
    check("R2 mask code 3 inside", 32'(trap_src), 32'd1);
    bus(1'b0, 1'b0, 2'd2, 32'h00133456, 32'h0, 8'h80);
    check("R2 mask code 3 outside", 32'(trap_src), 32'd0);
    reg_wr(4'd3, 32'd0);

    // R9: both channels on one cycle, then B alone
    reg_wr(4'd5, 32'h80);
    reg_wr(4'd6, 32'h00123456);
    reg_wr(4'd7, 32'd0);
    reg_wr(4'd8, 32'h40);
    bus(1'b0, 1'b0, 2'd2, 32'h00123454, 32'h0, 8'h80);
    check("R9 both channels same cycle", 32'(trap_src), 32'd3);

    // R11: register write in the same clock as a matching cycle
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd4; reg_wdata = 32'h0;
    set_cyc(1'b0, 1'b0, 2'd2, 32'h00123454, 32'h0, 8'h80);
    @(negedge clk);
    reg_we = 1'b0; cyc_valid = 1'b0;
    check("R11 old settings used", 32'(trap_src), 32'd3);
    bus(1'b0, 1'b0, 2'd2, 32'h00123454, 32'h0, 8'h80);
    check("R12/R9 A disabled, B still fires", 32'(trap_src), 32'd2);
    reg_wr(4'd8, 32'h0);

    // R8: fetch break, pre-execution then post-execution
    reg_wr(4'd2, 32'h00027128);
    reg_wr(4'd4, 32'h45);
    reg_wr(4'd0, 32'h2);
    bus(1'b1, 1'b0, 2'd1, 32'h00027128, 32'h0, 8'h80);
    check("R8 pre-execution fetch trap", 32'(trap_src), 32'd1);
    reg_wr(4'd0, 32'h0);
    bus(1'b1, 1'b0, 2'd1, 32'h00027128, 32'h0, 8'h80);
    check("R8 post-execution waits", 32'(trap_src), 32'd0);
    @(negedge clk);
    insn_retire = 1'b1;
    @(negedge clk);
    insn_retire = 1'b0;
    check("R8 post-execution after retire", 32'(trap_src), 32'd1);

    // R5: fetch+write condition and odd fetch address
    reg_wr(4'd4, 32'h49);
    bus(1'b1, 1'b1, 2'd1, 32'h00027128, 32'h0, 8'h80);
    check("R5 fetch write never fires", 32'(trap_src), 32'd0);
    reg_wr(4'd2, 32'h00031415);
    reg_wr(4'd4, 32'h45);
    reg_wr(4'd0, 32'h2);
    bus(1'b1, 1'b0, 2'd1, 32'h00031414, 32'h0, 8'h80);
    check("R5 odd fetch address never fires", 32'(trap_src), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule